// File: doc/BRIEF.md
# Clock Domain Sleep/Wake Controller

This block governs a single clock domain that contains several modules. It enables or gates the domain clock and runs an idle request / idle acknowledge handshake with every module that is set to follow the domain. A 2-bit transition control input selects one of four policies. The first keeps the domain awake but still lets wakeups happen. The second forces a sleep. The third forces a wakeup. The fourth lets hardware decide, using an inactivity monitor.

In the hardware policy, a prescaler divides the clock into time units. A window counter then measures how many of those units have passed since the last bus access. When the programmed window runs out, the domain begins a sleep transition. This happens only if no module is explicitly enabled, no enabled static dependency is active and no wake event is pending. The block reports a 2-bit idle status per module and a clock activity bit. For each bus access it decides whether to grant it, to hold it while the domain wakes, or to answer with an error.

Top module: `clkdom_sleep_ctrl`

## Requirements
- R1: After reset the domain clock is enabled, the clock activity bit is 1, no idle request is raised and every module reports idle status 3.
- R2: With transition control 0, no sleep transition begins, however long the bus stays quiet.
- R3: Transition control 1 starts a sleep transition. Idle request goes to every mode-1 module. The clock is gated only once all of those modules acknowledge. Clock activity reads 0 only while the clock is gated.
- R4: Transition control 2 wakes a gated domain and drops the idle requests. Mode-1 modules report status 1 while their acknowledge is still high, and status 0 once it falls.
- R5: With transition control 3, prescaler divide value P and window size W, a sleep transition begins W*(P+1)+1 cycles after the last cycle with a bus access. Any access restarts that count.
- R6: While any module is in mode 2, the domain does not sleep, and that module reports status 0.
- R7: An active dependency whose enable bit is 1 keeps the domain awake and wakes it from gated. An active dependency whose enable bit is 0 has no effect.
- R8: A bus access to a module in mode 0 or 3 returns an error, unless that module's own wake request is high. An access to a mode-1 or mode-2 module gets no error, and it is granted only while the domain is awake.
- R9: A new bus access or a module wake request during the acknowledge wait aborts the sleep. The idle requests drop, and mode-1 modules report status 1 until they are functional again.
- R10: With transition control 3, an access to a mode-1 module in a gated domain wakes the domain, and the access is granted once the domain is awake.
- R11: Idle status encoding: 0 is functional, 1 is in transition, 2 is idle (acknowledged or gated), and 3 is disabled. Module mode 3 behaves like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| transCtrl | input | 2 | 0 stay awake, 1 forced sleep, 2 forced wakeup, 3 hardware automatic |
| modMode | input | 2*NUM_MOD | Per-module mode, module i at bits [2i+1:2i]: 0 off, 1 follow domain, 2 forced on, 3 off |
| windowSize | input | 4 | Inactivity window length in prescaler ticks |
| prescaleDiv | input | PRESCALE_W | One prescaler tick every prescaleDiv+1 cycles |
| depEnable | input | NUM_DEP | Static dependency enable, 1 enabled |
| depActive | input | NUM_DEP | Activity of each dependent domain |
| busReq | input | 1 | Bus access present this cycle |
| busModSel | input | SEL_W | Target module of the access |
| modWakeReq | input | NUM_MOD | Asynchronous wake request per module |
| idleAck | input | NUM_MOD | Idle acknowledge per module |
| idleReq | output | NUM_MOD | Idle request per module |
| idleStatus | output | 2*NUM_MOD | Per-module idle status, module i at bits [2i+1:2i] |
| domClkEn | output | 1 | Domain clock enable |
| clkActivity | output | 1 | 0 only while the domain clock is gated |
| busGrant | output | 1 | Access accepted this cycle |
| busErr | output | 1 | Access rejected with error this cycle |

## Verification
The bench builds the block with four modules, three dependencies and a 4-bit prescaler. It programs a divide value of 2 and a window of 3, so the inactivity expiry lands nine cycles after an access and can be checked to the exact cycle, both with and without a reload in the middle. Four modules give a 2-bit select that covers every module, so the random phase reaches all mode encodings, including the reserved one, on every target. A module model with separate block and hold controls for the acknowledges can stall the sleep wait and keep the wakeup in transition, which brings the abort and status-1 cases within reach.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE     = 2'd0,
    ST_SLEEP_REQ = 2'd1,
    ST_GATED     = 2'd2,
    ST_WAKING    = 2'd3
  } domState_e;

  localparam logic [1:0] TC_NO_SLEEP = 2'd0;
  localparam logic [1:0] TC_SW_SLEEP = 2'd1;
  localparam logic [1:0] TC_SW_WAKE  = 2'd2;
  localparam logic [1:0] TC_HW_AUTO  = 2'd3;

  localparam logic [1:0] MM_AUTO = 2'd1;
  localparam logic [1:0] MM_ON   = 2'd2;

  localparam logic [1:0] IS_FUNC     = 2'd0;
  localparam logic [1:0] IS_TRANS    = 2'd1;
  localparam logic [1:0] IS_IDLE     = 2'd2;
  localparam logic [1:0] IS_DISABLED = 2'd3;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic monClear;
    logic monRun;
    logic reqIdle;
    logic waking;
    logic gated;
    logic awake;
  } ctrlStrobe_t;
endpackage

// File: rtl/cds_datapath.sv
module cds_datapath
  import cds_pkg::*;
#(
  parameter int NUM_MOD    = 4,
  parameter int NUM_DEP    = 3,
  parameter int PRESCALE_W = 4,
  parameter int WIN_W      = 4,
  parameter int SEL_W      = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [2*NUM_MOD-1:0]   modMode,
  input  logic [WIN_W-1:0]       windowSize,
  input  logic [PRESCALE_W-1:0]  prescaleDiv,
  input  logic [NUM_DEP-1:0]     depEnable,
  input  logic [NUM_DEP-1:0]     depActive,
  input  logic                   busReq,
  input  logic [SEL_W-1:0]       busModSel,
  input  logic [NUM_MOD-1:0]     modWakeReq,
  input  logic [NUM_MOD-1:0]     idleAck,
  output logic                   windowDone,
  output logic [NUM_MOD-1:0]     autoMask,
  output logic                   forceOnAny,
  output logic                   depHold,
  output logic                   accessWake,
  output logic                   busGrant,
  output logic                   busErr,
  output logic [2*NUM_MOD-1:0]   idleStatus
);
  logic [1:0] modeArr [NUM_MOD];
  logic [NUM_MOD-1:0] onMask;

  logic [PRESCALE_W-1:0] prescCnt;
  logic [WIN_W-1:0]      idleTicks;
  logic                  tick;

  // inactivity monitor: prescaler plus saturating window counter
  assign tick       = (prescCnt == prescaleDiv);
  assign windowDone = (idleTicks == windowSize);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      idleTicks <= '0;
    end else if (strobe.monClear || busReq) begin
      prescCnt  <= '0;
      idleTicks <= '0;
    end else if (strobe.monRun && !windowDone) begin
      if (tick) begin
        prescCnt  <= '0;
        idleTicks <= idleTicks + WIN_W'(1);
      end else begin
        prescCnt <= prescCnt + PRESCALE_W'(1);
      end
    end
  end

  // per-module decode and status
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    assign modeArr[i]  = modMode[2*i +: 2];
    assign autoMask[i] = (modeArr[i] == MM_AUTO);
    assign onMask[i]   = (modeArr[i] == MM_ON);

    always_comb begin
      if (modeArr[i] == MM_ON) begin
        idleStatus[2*i +: 2] = IS_FUNC;
      end else if (modeArr[i] == MM_AUTO) begin
        if (strobe.awake)
          idleStatus[2*i +: 2] = IS_FUNC;
        else if (strobe.gated)
          idleStatus[2*i +: 2] = IS_IDLE;
        else if (strobe.reqIdle && idleAck[i])
          idleStatus[2*i +: 2] = IS_IDLE;
        else
          idleStatus[2*i +: 2] = IS_TRANS;
      end else begin
        idleStatus[2*i +: 2] = IS_DISABLED;
      end
    end
  end

  assign forceOnAny = |onMask;
  assign depHold    = |(depEnable & depActive);

  // bus access decode
  logic [1:0] selMode;
  logic       selWake;
  logic       accOk;

  always_comb begin
    selMode = 2'd0;
    selWake = 1'b0;
    for (int i = 0; i < NUM_MOD; i++) begin
      if (busModSel == SEL_W'(i)) begin
        selMode = modeArr[i];
        selWake = modWakeReq[i];
      end
    end
  end

  assign accOk      = (selMode == MM_AUTO) || (selMode == MM_ON) || selWake;
  assign busErr     = busReq && !accOk;
  assign busGrant   = busReq && accOk && strobe.awake;
  assign accessWake = busReq && (selMode == MM_AUTO);

  // waking strobe is folded into the status decode above as IS_TRANS
  logic unusedWaking;
  assign unusedWaking = strobe.waking;
endmodule

// File: rtl/cds_ctrl.sv
module cds_ctrl
  import cds_pkg::*;
#(
  parameter int NUM_MOD = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         transCtrl,
  input  logic               windowDone,
  input  logic [NUM_MOD-1:0] autoMask,
  input  logic               forceOnAny,
  input  logic               depHold,
  input  logic               accessWake,
  input  logic               wakeAny,
  input  logic               busReq,
  input  logic [NUM_MOD-1:0] idleAck,
  output ctrlStrobe_t        strobe,
  output logic [NUM_MOD-1:0] idleReq,
  output logic               domClkEn,
  output logic               clkActivity
);
  domState_e state, stateNext;

  logic keepAwake, wakeEvt, sleepWanted, sleepOk, wakeNow, abortSleep;
  logic allAck, noAck;

  assign keepAwake   = forceOnAny || depHold;
  assign wakeEvt     = accessWake || wakeAny;
  assign sleepWanted = (transCtrl == TC_SW_SLEEP) ||
                       ((transCtrl == TC_HW_AUTO) && windowDone);
  assign sleepOk     = sleepWanted && !keepAwake && !wakeEvt && !busReq;
  assign wakeNow     = keepAwake || (transCtrl == TC_SW_WAKE) ||
                       ((transCtrl != TC_SW_SLEEP) && wakeEvt);
  assign abortSleep  = keepAwake || wakeEvt || busReq ||
                       (transCtrl == TC_NO_SLEEP) || (transCtrl == TC_SW_WAKE);
  assign allAck      = ((idleAck & autoMask) == autoMask);
  assign noAck       = ((idleAck & autoMask) == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_AWAKE:     if (sleepOk) stateNext = ST_SLEEP_REQ;
      ST_SLEEP_REQ: begin
        if (abortSleep)  stateNext = ST_WAKING;
        else if (allAck) stateNext = ST_GATED;
      end
      ST_GATED:     if (wakeNow) stateNext = ST_WAKING;
      ST_WAKING:    if (noAck) stateNext = ST_AWAKE;
      default:      stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.awake    = (state == ST_AWAKE);
    strobe.reqIdle  = (state == ST_SLEEP_REQ);
    strobe.gated    = (state == ST_GATED);
    strobe.waking   = (state == ST_WAKING);
    strobe.monRun   = (state == ST_AWAKE);
    strobe.monClear = (state != ST_AWAKE) || (transCtrl != TC_HW_AUTO);
  end

  assign idleReq     = (strobe.reqIdle || strobe.gated) ? autoMask : '0;
  assign domClkEn    = !strobe.gated;
  assign clkActivity = !strobe.gated;
endmodule

// File: rtl/clkdom_sleep_ctrl.sv
module clkdom_sleep_ctrl
  import cds_pkg::*;
#(
  parameter int NUM_MOD    = 4,
  parameter int NUM_DEP    = 3,
  parameter int PRESCALE_W = 4,
  localparam int WIN_W     = 4,
  localparam int SEL_W     = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            transCtrl,
  input  logic [2*NUM_MOD-1:0]  modMode,
  input  logic [WIN_W-1:0]      windowSize,
  input  logic [PRESCALE_W-1:0] prescaleDiv,
  input  logic [NUM_DEP-1:0]    depEnable,
  input  logic [NUM_DEP-1:0]    depActive,
  input  logic                  busReq,
  input  logic [SEL_W-1:0]      busModSel,
  input  logic [NUM_MOD-1:0]    modWakeReq,
  input  logic [NUM_MOD-1:0]    idleAck,
  output logic [NUM_MOD-1:0]    idleReq,
  output logic [2*NUM_MOD-1:0]  idleStatus,
  output logic                  domClkEn,
  output logic                  clkActivity,
  output logic                  busGrant,
  output logic                  busErr
);
  ctrlStrobe_t        strobe;
  logic               windowDone, forceOnAny, depHold, accessWake;
  logic [NUM_MOD-1:0] autoMask;

  cds_datapath #(
    .NUM_MOD(NUM_MOD), .NUM_DEP(NUM_DEP), .PRESCALE_W(PRESCALE_W),
    .WIN_W(WIN_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modMode(modMode),
    .windowSize(windowSize), .prescaleDiv(prescaleDiv),
    .depEnable(depEnable), .depActive(depActive), .busReq(busReq),
    .busModSel(busModSel), .modWakeReq(modWakeReq), .idleAck(idleAck),
    .windowDone(windowDone), .autoMask(autoMask), .forceOnAny(forceOnAny),
    .depHold(depHold), .accessWake(accessWake), .busGrant(busGrant),
    .busErr(busErr), .idleStatus(idleStatus)
  );

  cds_ctrl #(.NUM_MOD(NUM_MOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .transCtrl(transCtrl), .windowDone(windowDone),
    .autoMask(autoMask), .forceOnAny(forceOnAny), .depHold(depHold),
    .accessWake(accessWake), .wakeAny(|modWakeReq), .busReq(busReq),
    .idleAck(idleAck), .strobe(strobe), .idleReq(idleReq),
    .domClkEn(domClkEn), .clkActivity(clkActivity)
  );
endmodule

// File: rtl/clkdom_sleep_ctrl_chk.sv
module clkdom_sleep_ctrl_chk #(
  parameter int NUM_MOD = 4,
  parameter int NUM_DEP = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           transCtrl,
  input logic [2*NUM_MOD-1:0] modMode,
  input logic [NUM_DEP-1:0]   depEnable,
  input logic [NUM_DEP-1:0]   depActive,
  input logic [NUM_MOD-1:0]   idleAck,
  input logic [NUM_MOD-1:0]   idleReq,
  input logic [2*NUM_MOD-1:0] idleStatus,
  input logic                 domClkEn,
  input logic                 busGrant
);
  logic [NUM_MOD-1:0] forcedOn;
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_chk
    assign forcedOn[i] = (modMode[2*i +: 2] == 2'd2);

    assert_disabled_status_R11: assert property (@(posedge clk) disable iff (!rstN)
      (modMode[2*i +: 2] == 2'd0) |-> (idleStatus[2*i +: 2] == 2'd3));
  end

  assert_gate_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(domClkEn) |-> $past((idleAck & idleReq) == idleReq));

  assert_no_sleep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (transCtrl == 2'd0 && idleReq == '0) |=> (idleReq == '0));

  assert_forced_on_awake_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((|forcedOn) && domClkEn) |=> domClkEn);

  assert_dep_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|(depEnable & depActive)) && domClkEn) |=> domClkEn);

  assert_grant_clocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> domClkEn);
endmodule

bind clkdom_sleep_ctrl clkdom_sleep_ctrl_chk #(.NUM_MOD(NUM_MOD), .NUM_DEP(NUM_DEP)) u_chk (.*);

// File: tb/clkdom_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module clkdom_sleep_ctrl_bench;
  localparam int NM = 4;
  localparam int ND = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] transCtrl = 2'd0;
  logic [2*NM-1:0] modMode = '0;
  logic [3:0] windowSize = 4'd0;
  logic [PW-1:0] prescaleDiv = '0;
  logic [ND-1:0] depEnable = '0, depActive = '0;
  logic busReq = 1'b0;
  logic [1:0] busModSel = 2'd0;
  logic [NM-1:0] modWakeReq = '0;
  logic [NM-1:0] idleAck = '0;
  logic [NM-1:0] ackBlock = '0, ackHold = '0;
  logic [NM-1:0] idleReq;
  logic [2*NM-1:0] idleStatus;
  logic domClkEn, clkActivity, busGrant, busErr;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  clkdom_sleep_ctrl #(.NUM_MOD(NM), .NUM_DEP(ND), .PRESCALE_W(PW)) u_clkdom_sleep_ctrl (
    .clk(clk), .rstN(rstN), .transCtrl(transCtrl), .modMode(modMode),
    .windowSize(windowSize), .prescaleDiv(prescaleDiv), .depEnable(depEnable),
    .depActive(depActive), .busReq(busReq), .busModSel(busModSel),
    .modWakeReq(modWakeReq), .idleAck(idleAck), .idleReq(idleReq),
    .idleStatus(idleStatus), .domClkEn(domClkEn), .clkActivity(clkActivity),
    .busGrant(busGrant), .busErr(busErr)
  );

  // module model: acknowledge follows request unless blocked, optional hold
  always begin
    @(posedge clk);
    #2;
    idleAck = (idleReq & ~ackBlock) | (idleAck & ackHold);
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stat(input int i);
    return int'(idleStatus[2*i +: 2]);
  endfunction

  function automatic bit expErr(input logic [1:0] m, input bit wk);
    return !((m == 2'd1) || (m == 2'd2) || wk);
  endfunction

  function automatic int expAwakeStatus(input logic [1:0] m);
    return ((m == 2'd1) || (m == 2'd2)) ? 0 : 3;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    int got;
    seed = 1234;
    void'($urandom(seed));
    step(3);
    // R1 reset state
    chk("R1 clkEn", domClkEn, 1);
    chk("R1 activity", clkActivity, 1);
    chk("R1 idleReq", idleReq, 0);
    chk("R1 status", idleStatus, 8'hFF);
    rstN = 1'b1;
    step(2);
    chk("R1 status after release", idleStatus, 8'hFF);
    chk("R1 no error idle bus", busErr, 0);

    // R2 no sleep with control 0
    modMode = 8'h55;
    step(30);
    chk("R2 idleReq", idleReq, 0);
    chk("R2 clkEn", domClkEn, 1);
    chk("R11 functional status", idleStatus, 0);

    // R8 / R11 random access decode while awake
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m;
      modMode    = 8'($urandom());
      busModSel  = 2'($urandom());
      modWakeReq = 4'($urandom()) & 4'($urandom());
      busReq = 1'b1;
      #1;
      m = modMode[2*busModSel +: 2];
      chk("R8 busErr", busErr, expErr(m, modWakeReq[busModSel]));
      chk("R8 busGrant", busGrant, !expErr(m, modWakeReq[busModSel]));
      chk("R11 status", stat(busModSel), expAwakeStatus(m));
      step(1);
      busReq = 1'b0;
      modWakeReq = '0;
    end
    // directed R8: disabled target with its own wake request
    modMode = 8'h00; busModSel = 2'd2; modWakeReq = 4'b0100; busReq = 1'b1;
    #1;
    chk("R8 wake access no error", busErr, 0);
    chk("R8 wake access granted", busGrant, 1);
    modWakeReq = '0;
    #1;
    chk("R8 disabled access error", busErr, 1);
    busReq = 1'b0;
    step(1);

    // R3 forced sleep with one stalled acknowledge
    modMode = 8'h05; ackBlock = 4'b0010; transCtrl = 2'd1;
    step(1);
    chk("R3 idleReq", idleReq, 4'b0011);
    chk("R3 acked status", stat(0), 2);
    chk("R3 waiting status", stat(1), 1);
    chk("R3 activity in transition", clkActivity, 1);
    step(3);
    chk("R3 still clocked", domClkEn, 1);
    ackBlock = '0;
    step(1);
    chk("R3 not yet gated", clkActivity, 1);
    step(1);
    chk("R3 gated activity", clkActivity, 0);
    chk("R3 gated clkEn", domClkEn, 0);
    chk("R11 gated status", stat(1), 2);
    chk("R11 reserved disabled", stat(3), 3);

    // R4 forced wakeup with held acknowledge
    ackHold = 4'b0011;
    transCtrl = 2'd2;
    step(1);
    chk("R4 clkEn", domClkEn, 1);
    chk("R4 idleReq dropped", idleReq, 0);
    chk("R4 transition status", stat(0), 1);
    step(2);
    chk("R4 held status", stat(1), 1);
    ackHold = '0;
    step(3);
    chk("R4 functional", idleStatus[3:0], 0);

    // R6 forced-on module blocks sleep
    modMode = 8'h09; transCtrl = 2'd1;
    step(6);
    chk("R6 idleReq", idleReq, 0);
    chk("R6 clkEn", domClkEn, 1);
    chk("R6 status", stat(1), 0);
    modMode = 8'h01;
    step(3);
    chk("R6 sleeps after release", domClkEn, 0);

    // R7 dependencies
    depEnable = 3'b001; depActive = 3'b010;
    step(3);
    chk("R7 disabled dep ignored", domClkEn, 0);
    depActive = 3'b001;
    step(1);
    chk("R7 dep wakes", domClkEn, 1);
    step(6);
    chk("R7 dep holds", idleReq, 0);
    chk("R7 dep holds clk", domClkEn, 1);
    transCtrl = 2'd0; depActive = '0;
    step(3);

    // R5 inactivity window P=2 W=3 -> 9 ticks of cycles
    prescaleDiv = 4'd2; windowSize = 4'd3;
    transCtrl = 2'd3; busModSel = 2'd0; busReq = 1'b1;
    step(1);
    busReq = 1'b0;
    step(9);
    chk("R5 awake at window end", idleReq, 0);
    step(1);
    chk("R5 sleep begins", idleReq, 4'b0001);
    step(2);
    chk("R5 gated", domClkEn, 0);

    // R10 access to follow-mode module wakes the domain
    busReq = 1'b1; busModSel = 2'd0;
    #1;
    chk("R10 no grant while gated", busGrant, 0);
    chk("R10 no error", busErr, 0);
    step(1);
    chk("R10 woke", domClkEn, 1);
    got = 0;
    for (int k = 0; k < 5 && !got; k++) begin
      if (busGrant) got = 1;
      else step(1);
    end
    chk("R10 granted once awake", got, 1);
    step(1);
    busReq = 1'b0;
    // R5 reload in the middle of the window
    step(5);
    busReq = 1'b1;
    step(1);
    busReq = 1'b0;
    step(9);
    chk("R5 reload holds awake", idleReq, 0);
    step(1);
    chk("R5 reload then sleep", idleReq, 4'b0001);
    transCtrl = 2'd0;
    step(4);

    // R9 abort during acknowledge wait
    ackBlock = 4'b0001; transCtrl = 2'd1;
    step(2);
    chk("R9 waiting", idleReq, 4'b0001);
    chk("R9 waiting status", stat(0), 1);
    modWakeReq = 4'b0001;
    step(1);
    chk("R9 aborted idleReq", idleReq, 0);
    chk("R9 transition status", stat(0), 1);
    chk("R9 clocked", clkActivity, 1);
    transCtrl = 2'd0; modWakeReq = '0; ackBlock = '0;
    step(3);
    chk("R9 functional again", stat(0), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule